// File: doc/BRIEF.md
# Toggle-Tag Word Receiver

This block takes 16-bit words from a service processor that shares only a single register with it. There is no strobe and no ready line. The most significant bit of the shared register acts as a tag. The receiver keeps its own expected tag. When the register's tag equals that expected value, a fresh word is waiting. The register is written in another clock domain, so its value passes through a two-flop synchronizer before anything is compared with it.

A word is fetched only after a read request arrives. While a request is open, the receiver polls the synchronized tag. When the tag matches, it samples the synchronized word once more on the following cycle and delivers that second sample with a one-cycle valid pulse. It then inverts its expected tag and XORs the delivered word, tag bit included, into a running checksum. The checksum output can be read at any time.

A start pulse clears the checksum and the expected tag, and abandons any open request. The far side begins with the tag at 1, so the first word is taken only after the far side drives the tag to 0.

Top module: `toggle_rx`

## Requirements
- R1: After reset, `valid_o` is 0, `word_o` is 0 and `csum_o` is 0.
- R2: The expected tag is 0 after reset or start. While the synchronized bit 15 differs from the expected tag, no word is accepted, `valid_o` stays 0 and `csum_o` holds its value.
- R3: When bit 15 matches the expected tag during an open request, a word is delivered on `word_o` with `valid_o` high for exactly one cycle.
- R4: After each delivered word the expected tag inverts, so delivered words alternate between bit 15 = 0 and bit 15 = 1.
- R5: The delivered word is a second synchronized sample, taken one cycle after the cycle in which the tag match was seen, not the sample that was tested.
- R6: `csum_o` equals the XOR of every 16-bit word delivered since the last reset or start, tag bit included.
- R7: One request yields at most one word. A request raised while a request is already open is ignored. Without an open request, a matching tag is not consumed.
- R8: `start_i` clears `csum_o` to 0, clears the expected tag and drops any open request. It takes priority over a delivery falling in the same cycle, so that delivery produces no valid pulse and leaves the checksum at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cp_word_i | input | 16 | Shared register value, asynchronous; bit 15 is the tag |
| start_i | input | 1 | Synchronous clear of tag, checksum and open request |
| req_i | input | 1 | Read request, one cycle wide |
| word_o | output | 16 | Last delivered word |
| valid_o | output | 1 | One-cycle pulse marking a new `word_o` |
| csum_o | output | 16 | Running XOR checksum |

## Verification
A start pulse and a word delivery can land on the same clock edge. The bench raises a request while a matching word has been settled in the synchronizer. It then asserts start exactly two edges after the request edge, which is the edge on which the delivery would otherwise complete. It judges the result by requiring no valid pulse and a zero checksum. It then confirms that a word with tag 0 is taken next, with the checksum equal to that word alone.

// File: rtl/toggle_rx_pkg.sv
package toggle_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_POLL = 2'd1,
    RX_TAKE = 2'd2
  } rx_state_e;
endpackage

// File: rtl/toggle_rx_sync.sv
module toggle_rx_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/toggle_rx_ctrl.sv
module toggle_rx_ctrl
  import toggle_rx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic req_i,
  input  logic tag_i,
  output logic take_o
);
  rx_state_e state_q, state_d;
  logic      tag_q, tag_d;

  always_comb begin
    state_d = state_q;
    tag_d   = tag_q;
    take_o  = 1'b0;
    if (start_i) begin
      state_d = RX_IDLE;
      tag_d   = 1'b0;
    end else begin
      unique case (state_q)
        RX_IDLE: if (req_i) state_d = RX_POLL;
        RX_POLL: if (tag_i == tag_q) state_d = RX_TAKE;
        RX_TAKE: begin
          take_o  = 1'b1;
          tag_d   = ~tag_q;
          state_d = RX_IDLE;
        end
        default: state_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      tag_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      tag_q   <= tag_d;
    end
  end

  // R4: every accepted word flips the expected tag
  a_r4_tag_flips: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> (tag_q != $past(tag_q)));
  // R8: start returns to idle with tag cleared
  a_r8_start_clears_tag: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!tag_q && state_q == RX_IDLE));
endmodule

// File: rtl/toggle_rx_accum.sv
module toggle_rx_accum #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             take_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] word_o,
  output logic             valid_o,
  output logic [WIDTH-1:0] csum_o
);
  logic [WIDTH-1:0] word_q, word_d, csum_q, csum_d;
  logic             valid_q, valid_d;
  logic             word_en;

  assign word_en = take_i && !start_i;

  always_comb begin
    valid_d = word_en;
    word_d  = word_q;
    csum_d  = csum_q;
    if (start_i) begin
      csum_d = '0;
    end else if (word_en) begin
      word_d = data_i;
      csum_d = csum_q ^ data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      csum_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      word_q  <= word_d;
      csum_q  <= csum_d;
      valid_q <= valid_d;
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;
  assign csum_o  = csum_q;

  // R3: valid is a single-cycle pulse
  a_r3_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);
  // R6: checksum moves only on a delivery or a start
  a_r6_csum_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(csum_q) |-> (valid_q || $past(start_i)));
  // R8: start leaves a zero checksum and no pulse
  a_r8_start_wins: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (csum_q == '0 && !valid_q));
endmodule

// File: rtl/toggle_rx.sv
module toggle_rx #(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] cp_word_i,
  input  logic             start_i,
  input  logic             req_i,
  output logic [WIDTH-1:0] word_o,
  output logic             valid_o,
  output logic [WIDTH-1:0] csum_o
);
  localparam int TAG_BIT = WIDTH - 1;

  logic [1:0]       rst_pipe_q;
  logic             rst_int_n;
  logic [WIDTH-1:0] cp_sync;
  logic             take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  toggle_rx_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) sync_i (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   (cp_word_i),
    .q_o   (cp_sync)
  );

  toggle_rx_ctrl ctrl_i (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start_i (start_i),
    .req_i   (req_i),
    .tag_i   (cp_sync[TAG_BIT]),
    .take_o  (take)
  );

  toggle_rx_accum #(.WIDTH(WIDTH)) accum_i (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start_i (start_i),
    .take_i  (take),
    .data_i  (cp_sync),
    .word_o  (word_o),
    .valid_o (valid_o),
    .csum_o  (csum_o)
  );
endmodule

// File: tb/toggle_rx_tb_top.sv
module toggle_rx_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cp_word = 16'h8000;
  logic        start = 1'b0;
  logic        req = 1'b0;
  logic [15:0] word_o, csum_o;
  logic        valid_o;
  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  toggle_rx dut_i (
    .clk(clk), .rst_n(rst_n), .cp_word_i(cp_word), .start_i(start),
    .req_i(req), .word_o(word_o), .valid_o(valid_o), .csum_o(csum_o)
  );

  // {word, expected checksum after it}; tags alternate 0,1,0,1,0
  localparam logic [31:0] VEC [5] = '{
    {16'h0012, 16'h0012},
    {16'h8034, 16'h8026},
    {16'h7ABC, 16'hFA9A},
    {16'hFFFF, 16'h0565},
    {16'h0000, 16'h0565}
  };

  task automatic check(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  task automatic pulse_req();
    @(negedge clk) req = 1'b1;
    @(negedge clk) req = 1'b0;
  endtask

  // waits at negedges for valid; returns count of valid cycles seen
  task automatic wait_valid(input int maxc, output int seen);
    seen = 0;
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      if (valid_o) begin
        seen++;
        break;
      end
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 valid", {31'd0, valid_o}, 32'd0);
    check("R1 word", {16'd0, word_o}, 32'd0);
    check("R1 csum", {16'd0, csum_o}, 32'd0);

    // R2: far side starts with tag 1 -> no acceptance
    pulse_req();
    wait_valid(15, seen);
    check("R2 no accept on tag 1", seen, 0);
    check("R2 csum held", {16'd0, csum_o}, 32'd0);

    // table walk (request from above is still open for entry 0)
    for (int k = 0; k < 5; k++) begin
      @(negedge clk) cp_word = VEC[k][31:16];
      if (k != 0) pulse_req();
      wait_valid(15, seen);
      check("R3 valid seen", seen, 1);
      check("R4 word", {16'd0, word_o}, {16'd0, VEC[k][31:16]});
      check("R6 csum", {16'd0, csum_o}, {16'd0, VEC[k][15:0]});
      @(negedge clk);
      check("R3 single pulse", {31'd0, valid_o}, 32'd0);
    end

    // R7: two requests back to back, expected tag now 1
    @(negedge clk) cp_word = 16'h8001;
    repeat (3) @(negedge clk);
    @(negedge clk) req = 1'b1;
    @(negedge clk) req = 1'b1;
    @(negedge clk) req = 1'b0;
    seen = 0;
    for (int i = 0; i < 12; i++) begin
      if (valid_o) seen++;
      @(negedge clk);
    end
    check("R7 one word per open request", seen, 1);
    check("R7 csum", {16'd0, csum_o}, 32'h0000_8564);
    // matching tag-0 word without a request is not consumed
    @(negedge clk) cp_word = 16'h0100;
    wait_valid(12, seen);
    check("R7 no request no accept", seen, 0);
    pulse_req();
    wait_valid(12, seen);
    check("R7 accept after request", {16'd0, word_o}, 32'h0000_0100);

    // R5: tag match on A, data changes to B one cycle later -> B delivered
    @(negedge clk) cp_word = 16'h0200;          // tag 0, expected is 1
    repeat (4) @(negedge clk);
    pulse_req();
    repeat (3) @(negedge clk);
    cp_word = 16'h8AAA;                          // A, matching tag
    @(negedge clk) cp_word = 16'h8BBB;           // B, same tag
    wait_valid(12, seen);
    check("R5 resampled word", {16'd0, word_o}, 32'h0000_8BBB);

    // R8: start alone clears checksum and tag
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check("R8 csum cleared", {16'd0, csum_o}, 32'd0);
    cp_word = 16'h8123;
    repeat (4) @(negedge clk);
    pulse_req();
    wait_valid(12, seen);
    check("R2 tag cleared by start", seen, 0);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;

    // R8: start on the same edge as a delivery
    cp_word = 16'h0444;
    repeat (4) @(negedge clk);
    req = 1'b1;
    @(negedge clk) req = 1'b0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) begin
      start = 1'b0;
      check("R8 no valid on collision", {31'd0, valid_o}, 32'd0);
      check("R8 csum zero on collision", {16'd0, csum_o}, 32'd0);
    end
    pulse_req();
    wait_valid(12, seen);
    check("R8 next word after collision", seen, 1);
    check("R6 csum after collision", {16'd0, csum_o}, 32'h0000_0444);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule